// File: doc/BRIEF.md
# Real-Time Clock Interrupt Core

This core keeps a clock of seconds, minutes and hours that is advanced by a 32.768 kHz timebase. The timebase arrives as a one-cycle enable pulse, `tick`, in the system clock domain. A 15-bit divider counts these pulses and steps the time once per second. Each step raises an update flag. When the new time equals the three alarm fields, the same step also raises an alarm flag. Independently of the seconds, the divider taps a periodic flag and a square wave at a rate picked by a 4-bit code.

The host reaches every register through two ports. Address 0 holds a 7-bit index, and address 1 reads or writes the register that index selects. Control register A (index 10) holds the divider control, the rate code and a read-only update-in-progress bit. Control register B (index 11) holds the halt bit, the interrupt enables, the square-wave enable and the number format. The flag register (index 12) is read-only, and so is the power register (index 13). The interrupt output goes high when a pending flag has its enable set. Software reads the flag register to find the cause, and that read acknowledges it.

Top module: `rtc_core`

## Requirements
- R1: Writing address 0 stores bus_wdata[6:0] as the index. Reading address 0 returns {0, index}. At address 1, indices 0, 2 and 4 are the second, minute and hour, and 1, 3 and 5 are their alarm fields. Indices not listed here read 0 and ignore writes. Reset clears the index and every register.
- R2: The divider advances only on `tick` while A[6:4] is 010, and it wraps after 32768 ticks. Any other A[6:4] code, including 110 and 111, holds it at zero.
- R3: The second, minute and hour step once at each divider wrap. Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0. B[2]=1 counts in binary, and B[2]=0 counts in packed BCD (09 is followed by 10). A host write to a field in the same cycle takes priority over the step.
- R4: While B[7]=1, the time fields do not step and neither the update flag nor the alarm flag is set. The divider keeps running.
- R5: A[7] reads 1 during the last 8 divider counts before a step, while the divider runs and B[7]=0, and reads 0 otherwise. Writes to A[7] are ignored.
- R6: Rate code r=A[3:0] sets the periodic flag every 2^(r-1) ticks for r from 3 to 15. Codes 1 and 2 give 128 and 256 ticks. Code 0 never sets it. Periods are aligned to the divider count.
- R7: While B[3]=1 and r is non-zero, `sqw` is a square wave with the periodic period and a 50% duty cycle. Otherwise `sqw` is 0.
- R8: Every step sets the update flag. A step whose new second, minute and hour all equal the alarm fields sets the alarm flag.
- R9: The flag register reads {IRQF, periodic, alarm, update, 0000}. IRQF and `irq` are 1 when the periodic, alarm or update flag is set together with its enable, B[6], B[5] or B[4] respectively.
- R10: A read of the flag register returns the flags and clears them at that clock edge, unless a flag is set again in the same edge. The flag and power registers ignore writes, and the power register reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle 32.768 kHz timebase enable |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe (acknowledges the flag register) |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data, combinational from current state |
| irq | output | 1 | Interrupt request, high while IRQF is set |
| sqw | output | 1 | Square-wave output |

## Verification
The read data is combinational, so a read shows the state left by the last clock edge in that same cycle. A flag raised by a tick appears one edge after that tick, and its clear takes effect at the edge that ends the read. A divider restarted through A[6:4] steps the time exactly 32768 ticks after the write that restarts it. `irq` and `sqw` follow the registers with no further delay. The bench drives inputs on the falling edge. Its behavioural model steps at the rising edge, and all comparisons are made 2 ns after that edge, when the register outputs and the combinational read data have both settled.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DIV_W    = 15,
  parameter int UIP_LEAD = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sqw
);
  localparam logic [DIV_W-1:0] DIV_MAX  = '1;
  localparam logic [DIV_W-1:0] UIP_FROM = DIV_MAX - DIV_W'(UIP_LEAD - 1);

  logic [6:0] idx;
  logic [7:0] sec, min, hr, asec, amin, ahr;
  logic [6:0] reg_a;
  logic [7:0] reg_b;
  logic pf, af, uf;
  logic [DIV_W-1:0] div;

  wire run    = reg_a[6:4] == 3'b010;
  wire halt   = reg_b[7];
  wire bcd    = ~reg_b[2];
  wire step   = tick & run;
  wire upd    = step & (div == DIV_MAX) & ~halt;
  wire uip    = run & ~halt & (div >= UIP_FROM);
  wire wr_idx = bus_wr & ~bus_addr;
  wire wr_dat = bus_wr & bus_addr;
  wire rd_c   = bus_rd & bus_addr & (idx == 7'd12);

  function automatic logic [8:0] bump(input logic [7:0] v, input logic [7:0] last, input logic b);
    if (v == last) return {1'b1, 8'h00};
    if (b && v[3:0] == 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    return {1'b0, v + 8'd1};
  endfunction

  logic [8:0] s_b, m_b, h_b;
  assign s_b = bump(sec, bcd ? 8'h59 : 8'd59, bcd);
  assign m_b = bump(min, bcd ? 8'h59 : 8'd59, bcd);
  assign h_b = bump(hr,  bcd ? 8'h23 : 8'd23, bcd);

  wire [7:0] nsec = s_b[7:0];
  wire [7:0] nmin = s_b[8] ? m_b[7:0] : min;
  wire [7:0] nhr  = (s_b[8] & m_b[8]) ? h_b[7:0] : hr;
  wire alarm_hit  = (nsec == asec) & (nmin == amin) & (nhr == ahr);

  logic [3:0] pk;
  always_comb begin
    if (reg_a[3:0] == 4'd0)     pk = 4'd0;
    else if (reg_a[3:0] < 4'd3) pk = reg_a[3:0] + 4'd6;
    else                        pk = reg_a[3:0] - 4'd1;
  end
  wire [DIV_W-1:0] pmask = (DIV_W'(1) << pk) - DIV_W'(1);
  wire per_hit = step & (reg_a[3:0] != 4'd0) & ((div & pmask) == pmask);

  assign sqw = reg_b[3] & run & (reg_a[3:0] != 4'd0) & (|(div & (pmask ^ (pmask >> 1))));
  assign irq = (pf & reg_b[6]) | (af & reg_b[5]) | (uf & reg_b[4]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; sec <= '0; min <= '0; hr <= '0;
      asec <= '0; amin <= '0; ahr <= '0;
      reg_a <= '0; reg_b <= '0;
      pf <= 1'b0; af <= 1'b0; uf <= 1'b0;
      div <= '0;
    end else begin
      if (wr_idx) idx <= bus_wdata[6:0];
      div <= run ? (step ? div + DIV_W'(1) : div) : '0;
      if (upd) begin
        sec <= nsec; min <= nmin; hr <= nhr;
      end
      if (wr_dat) begin
        case (idx)
          7'd0:  sec   <= bus_wdata;
          7'd1:  asec  <= bus_wdata;
          7'd2:  min   <= bus_wdata;
          7'd3:  amin  <= bus_wdata;
          7'd4:  hr    <= bus_wdata;
          7'd5:  ahr   <= bus_wdata;
          7'd10: reg_a <= bus_wdata[6:0];
          7'd11: reg_b <= bus_wdata;
          default: ;
        endcase
      end
      pf <= per_hit | (pf & ~rd_c);
      uf <= upd | (uf & ~rd_c);
      af <= (upd & alarm_hit) | (af & ~rd_c);
    end
  end

  always_comb begin
    if (!bus_addr) bus_rdata = {1'b0, idx};
    else begin
      case (idx)
        7'd0:  bus_rdata = sec;
        7'd1:  bus_rdata = asec;
        7'd2:  bus_rdata = min;
        7'd3:  bus_rdata = amin;
        7'd4:  bus_rdata = hr;
        7'd5:  bus_rdata = ahr;
        7'd10: bus_rdata = {uip, reg_a};
        7'd11: bus_rdata = reg_b;
        7'd12: bus_rdata = {irq, pf, af, uf, 4'b0000};
        7'd13: bus_rdata = 8'h80;
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  // R5
  uip_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) upd |=> !uip);
  // R4
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (halt && !wr_dat) |=> $stable(sec));
  // R2
  stopped_div_chk: assert property (@(posedge clk) disable iff (!rst_n) !run |=> !$rose(uf));
  // R10
  c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) (rd_c && !step) |=> (!pf && !af && !uf));
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> ($past(step) || $past(bus_wr)));
endmodule

// File: tb/test_rtc_core.sv
module test_rtc_core;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic irq, sqw;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rtc_core i_rtc_core (.clk, .rst_n, .tick, .bus_wr, .bus_rd, .bus_addr,
                       .bus_wdata, .bus_rdata, .irq, .sqw);

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_idx, m_sec, m_min, m_hr, m_as, m_am, m_ah, m_a, m_b, m_div;
  bit m_pf, m_af, m_uf;
  int r, k, s, mi, h;
  bit run, step, halt, per, upd, ahit, rdc, bcdm;

  function automatic int to_i(int v, bit b);
    return b ? (v / 16) * 10 + (v % 16) : v;
  endfunction
  function automatic int fr_i(int v, bit b);
    return b ? (v / 10) * 16 + (v % 10) : v;
  endfunction
  function automatic int per_k(int rc);
    if (rc == 0) return 0;
    if (rc < 3) return rc + 6;
    return rc - 1;
  endfunction

  function automatic bit m_irq();
    return (m_pf && m_b[6]) || (m_af && m_b[5]) || (m_uf && m_b[4]);
  endfunction

  function automatic int m_rdata();
    bit u;
    u = ((m_a >> 4) == 2) && !m_b[7] && m_div >= 32760;
    if (!bus_addr) return m_idx;
    case (m_idx)
      0: return m_sec;  1: return m_as;
      2: return m_min;  3: return m_am;
      4: return m_hr;   5: return m_ah;
      10: return u * 128 + m_a;
      11: return m_b;
      12: return m_irq() * 128 + m_pf * 64 + m_af * 32 + m_uf * 16;
      13: return 128;
      default: return 0;
    endcase
  endfunction

  function automatic bit m_sqw();
    int kk;
    kk = per_k(m_a % 16);
    if (!m_b[3] || (m_a >> 4) != 2 || kk == 0) return 0;
    return ((m_div >> (kk - 1)) % 2) == 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_idx = 0; m_sec = 0; m_min = 0; m_hr = 0; m_as = 0; m_am = 0; m_ah = 0;
      m_a = 0; m_b = 0; m_div = 0; m_pf = 0; m_af = 0; m_uf = 0;
    end else begin
      run  = (m_a >> 4) == 2;
      step = tick && run;
      halt = m_b[7];
      bcdm = !m_b[2];
      r = m_a % 16;
      k = per_k(r);
      per = step && r != 0 && (m_div % (1 << k)) == (1 << k) - 1;
      upd = step && m_div == 32767 && !halt;
      ahit = 0;
      rdc = bus_rd && bus_addr && m_idx == 12;
      if (upd) begin
        s = to_i(m_sec, bcdm) + 1; mi = to_i(m_min, bcdm); h = to_i(m_hr, bcdm);
        if (s == 60) begin
          s = 0; mi++;
          if (mi == 60) begin mi = 0; h = (h + 1) % 24; end
        end
        m_sec = fr_i(s, bcdm); m_min = fr_i(mi, bcdm); m_hr = fr_i(h, bcdm);
        ahit = m_sec == m_as && m_min == m_am && m_hr == m_ah;
      end
      m_div = run ? (step ? (m_div + 1) % 32768 : m_div) : 0;
      if (bus_wr && bus_addr) begin
        case (m_idx)
          0: m_sec = bus_wdata;  1: m_as = bus_wdata;
          2: m_min = bus_wdata;  3: m_am = bus_wdata;
          4: m_hr = bus_wdata;   5: m_ah = bus_wdata;
          10: m_a = bus_wdata % 128;
          11: m_b = bus_wdata;
          default: ;
        endcase
      end
      if (bus_wr && !bus_addr) m_idx = bus_wdata % 128;
      m_pf = per || (m_pf && !rdc);
      m_uf = upd || (m_uf && !rdc);
      m_af = (upd && ahit) || (m_af && !rdc);
    end
    #2;
    if (rst_n && !done) begin
      chk("R9", "irq vs model", irq, m_irq());
      chk("R7", "sqw vs model", sqw, m_sqw());
      chk("R1", "rdata vs model", bus_rdata, m_rdata());
    end
  end

  task automatic wr_reg(input int ix, input int val);
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 8'(ix);
    @(negedge clk); bus_addr = 1; bus_wdata = 8'(val);
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_reg(input int ix, input int exp, input string req, input string what);
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 8'(ix);
    @(negedge clk); bus_wr = 0; bus_addr = 1; bus_rd = 1;
    #1 chk(req, what, bus_rdata, exp);
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic clr_c();
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 8'd12;
    @(negedge clk); bus_wr = 0; bus_addr = 1; bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd_reg(12, 8'h00, "R1", "flags after reset");
    rd_reg(13, 8'h80, "R10", "power register");
    rd_reg(10, 8'h00, "R1", "reg A after reset");
    chk("R9", "irq after reset", irq, 0);

    // periodic, rate 3 (4 ticks)
    wr_reg(11, 8'h40);
    wr_reg(10, 8'h23);
    idle(20);
    rd_reg(12, 8'hC0, "R6", "rate 3 flag");
    // rate 1 aliases to 128 ticks, aligned after restart
    wr_reg(10, 8'h61);
    clr_c();
    wr_reg(10, 8'h21);
    idle(100);
    rd_reg(12, 8'h00, "R6", "rate 1 before 128 ticks");
    idle(40);
    rd_reg(12, 8'hC0, "R6", "rate 1 after 128 ticks");
    // code 0 never sets the flag
    wr_reg(10, 8'h20);
    clr_c();
    idle(200);
    rd_reg(12, 8'h00, "R6", "rate 0 no flag");

    // tick gating and divider hold (R2)
    tick = 0;
    wr_reg(10, 8'h63);
    clr_c();
    wr_reg(10, 8'h23);
    repeat (3) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
    rd_reg(12, 8'h00, "R2", "three ticks, no flag");
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    rd_reg(12, 8'hC0, "R2", "fourth tick sets flag");
    @(negedge clk); tick = 1;

    // read coinciding with flag setting (R10)
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 8'd12;
    @(negedge clk); bus_wr = 0; bus_addr = 1; bus_rd = 1;
    idle(9);
    bus_rd = 0;
    idle(2);

    // square wave, rate 4 (8 ticks)
    wr_reg(11, 8'h08);
    wr_reg(10, 8'h24);
    idle(3);
    hi = 0;
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #2 if (sqw) hi++;
    end
    chk("R7", "sqw high count over 32", hi, 16);
    wr_reg(11, 8'h00);

    // BCD stepping with carry and alarm
    wr_reg(11, 8'h30);
    wr_reg(10, 8'h60);
    wr_reg(0, 8'h59); wr_reg(2, 8'h09); wr_reg(4, 8'h23);
    wr_reg(1, 8'h00); wr_reg(3, 8'h10); wr_reg(5, 8'h23);
    clr_c();
    wr_reg(10, 8'h20);
    @(negedge clk); bus_addr = 1;
    hi = 0;
    for (int i = 0; i < 32800; i++) begin
      @(posedge clk); #2 if (bus_rdata[7]) hi++;
    end
    chk("R5", "update-in-progress cycles", hi, 8);
    rd_reg(0, 8'h00, "R3", "BCD second wrap");
    rd_reg(2, 8'h10, "R3", "BCD minute 09 to 10");
    rd_reg(4, 8'h23, "R3", "BCD hour held");
    rd_reg(12, 8'hB0, "R8", "alarm and update flags");
    rd_reg(12, 8'h00, "R10", "flags cleared by read");

    // binary stepping, no alarm match
    wr_reg(11, 8'h34);
    wr_reg(10, 8'h60);
    wr_reg(0, 59); wr_reg(2, 59); wr_reg(4, 23);
    wr_reg(1, 1); wr_reg(3, 2); wr_reg(5, 3);
    clr_c();
    wr_reg(10, 8'h20);
    idle(32800);
    rd_reg(0, 0, "R3", "binary second wrap");
    rd_reg(2, 0, "R3", "binary minute wrap");
    rd_reg(4, 0, "R3", "binary hour 23 to 0");
    rd_reg(12, 8'h90, "R8", "update flag only");

    // halt
    wr_reg(11, 8'hB0);
    wr_reg(10, 8'h60);
    wr_reg(0, 8'h05);
    clr_c();
    wr_reg(10, 8'h20);
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 8'd10;
    @(negedge clk); bus_wr = 0; bus_addr = 1;
    hi = 0;
    for (int i = 0; i < 32800; i++) begin
      @(posedge clk); #2 if (bus_rdata[7]) hi++;
    end
    chk("R5", "no update-in-progress while halted", hi, 0);
    rd_reg(0, 8'h05, "R4", "second held while halted");
    rd_reg(12, 8'h00, "R4", "no flags while halted");
    wr_reg(11, 8'h00);

    // ignored writes and unused indices
    wr_reg(12, 8'hFF);
    rd_reg(12, 8'h00, "R10", "flag register ignores write");
    wr_reg(13, 8'h00);
    rd_reg(13, 8'h80, "R10", "power register ignores write");
    wr_reg(10, 8'hA0);
    rd_reg(10, 8'h20, "R5", "A bit 7 not writable");
    wr_reg(8'h30, 8'h55);
    rd_reg(8'h30, 8'h00, "R1", "unused index");
    @(negedge clk); bus_addr = 0; bus_wr = 1; bus_wdata = 8'h05;
    @(negedge clk); bus_wr = 0;
    #1 chk("R1", "index port readback", bus_rdata, 8'h05);

    idle(2);
    summary();
    $finish;
  end
endmodule